// File: doc/BRIEF.md
# PWM Compare Channel with Preloadable Compare Value

This block is one output-compare channel of a timer. A shared counter is outside it. The channel compares the counter value with a compare value that software programs. From that comparison it makes a registered output reference level in one of two pulse-width modes. A small write port loads a configuration word and the compare value.

The compare value can go straight into the comparison, or it can wait in a holding register and move into the active register on an update-event strobe. The channel also has an immediate-active option. When a trigger strobe arrives, the output jumps to the level a compare match would give, whatever the counter holds. It stays there until the next overflow/underflow strobe, and then the normal comparison takes over again.

Top module: `pwm_compare_channel`

## Requirements
- R1: After reset the configuration word reads 0 (mode 0, preload off, immediate-active off), the output reference is 0 and no forced period is running.
- R2: Configuration word layout: bit 8 is mode bit 3, bits 2:0 are mode bits 2:0, bit 4 enables preload, bit 5 enables immediate-active. Every other bit is ignored on write and reads back as 0 on `cfg_rdata`.
- R3: In mode 4'b0110 (first pulse mode), the output sampled after clock edge N is 1 when the counter at edge N is below the active compare value, and 0 otherwise.
- R4: In mode 4'b0111 (second pulse mode), the output is the inverse of R3: 1 when the counter is at or above the active compare value.
- R5: Every other mode code holds the output at 0.
- R6: With preload off, a compare write (`wr_sel`=1) changes the active compare value at the same edge, so the output after the next edge uses the new value.
- R7: With preload on, a compare write only fills the holding register. The active value changes only on an edge with `upd_ev`=1, and it then takes the holding content, which includes a write made on that same edge.
- R8: With immediate-active enabled in either pulse mode, a `trig` pulse sets the output at that edge to the match level (0 in the first pulse mode, 1 in the second), whatever the counter and compare values are.
- R9: The forced level lasts until an edge with `ovf_udf`=1. From that edge on, the output follows R3/R4. A trigger on that same edge, or during the forced period, neither starts nor extends a forced period.
- R10: A trigger has no effect when immediate-active is off, or when the mode is not a pulse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 selects the configuration word, 1 selects the compare value |
| wr_data | input | WR_W | Write data (WR_W = max(CNT_W, 9)) |
| cnt | input | CNT_W | Shared counter value |
| ovf_udf | input | 1 | Counter overflow/underflow strobe |
| upd_ev | input | 1 | Update-event strobe |
| trig | input | 1 | Trigger strobe |
| cfg_rdata | output | WR_W | Configuration word read-back |
| oref | output | 1 | Output reference level |

## Verification
The hardest conditions to reach are the overlaps around the forced period: a trigger on the same edge as an overflow, a second trigger while a forced period is running, and a trigger in a non-pulse mode followed by a switch to a pulse mode. The bench reaches each one by sequencing the strobes and mode writes one edge at a time. It then reads the output against the expected comparison level, so a leaked or extended forced state shows at the port. The duty checks sweep every counter value against boundary compare values in both pulse modes.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
    localparam logic [3:0] MODE_PWM_LO = 4'b0110;
    localparam logic [3:0] MODE_PWM_HI = 4'b0111;

    typedef struct packed {
        logic [3:0] mode;
        logic       pre;
        logic       imae;
    } cfg_t;
endpackage

// File: rtl/pwmc_cfg_reg.sv
module pwmc_cfg_reg
    import pwmc_pkg::*;
#(
    parameter int WR_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_cfg,
    input  logic [WR_W-1:0] wdata,
    output cfg_t            cfg,
    output logic [WR_W-1:0] rdata
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_cfg) begin
            cfg_d.mode = {wdata[8], wdata[2:0]};
            cfg_d.pre  = wdata[4];
            cfg_d.imae = wdata[5];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata    = '0;
        rdata[8] = cfg_q.mode[3];
        rdata[2:0] = cfg_q.mode[2:0];
        rdata[4] = cfg_q.pre;
        rdata[5] = cfg_q.imae;
    end

    assign cfg = cfg_q;

    // R2: reserved read-back bits stay zero
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[7:6] == 2'b00) && (rdata[3] == 1'b0));
endmodule

// File: rtl/pwmc_cmp_shadow.sv
module pwmc_cmp_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wdata,
    input  logic             pre,
    input  logic             upd,
    output logic [CNT_W-1:0] act
);
    typedef struct packed {
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cmp) st_d.hold = wdata;
        if (!pre) begin
            if (wr_cmp) st_d.act = wdata;
        end else if (upd) begin
            st_d.act = st_d.hold;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act = st_q.act;

    // R6: direct write lands in the active value at once
    p_direct_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && !pre) |=> (act == $past(wdata)));
    // R7: buffered value held until an update event
    p_preload_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && !upd) |=> $stable(act));
endmodule

// File: rtl/pwmc_out_gen.sv
module pwmc_out_gen
    import pwmc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [3:0]       mode,
    input  logic             imae,
    input  logic             trig,
    input  logic             ovf,
    output logic             oref
);
    typedef struct packed {
        logic frc;
        logic oref;
    } st_t;

    st_t  st_d, st_q;
    logic is_pwm;
    logic hi_mode;
    logic cmp_lvl;

    always_comb begin
        hi_mode = (mode == MODE_PWM_HI);
        is_pwm  = (mode == MODE_PWM_LO) || hi_mode;
        cmp_lvl = (cnt < cmp) ^ hi_mode;
        st_d = st_q;
        if (ovf)                           st_d.frc = 1'b0;
        else if (trig && imae && is_pwm)   st_d.frc = 1'b1;
        if (!is_pwm)        st_d.oref = 1'b0;
        else if (st_d.frc)  st_d.oref = hi_mode;
        else                st_d.oref = cmp_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oref = st_q.oref;

    // R9: overflow always ends the forced period
    p_force_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !st_q.frc);
    // R5: non-pulse modes keep the output low
    p_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !is_pwm |=> !oref);
    // R10: an unqualified trigger cannot start a forced period
    p_trig_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !(imae && is_pwm) && !st_q.frc) |=> !st_q.frc);
    // R8: a qualified trigger gives the match level
    p_force_lvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && imae && is_pwm && !ovf) |=> (oref == $past(hi_mode)));
endmodule

// File: rtl/pwm_compare_channel.sv
module pwm_compare_channel
    import pwmc_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int WR_W = (CNT_W > 9) ? CNT_W : 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [WR_W-1:0]  wr_data,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ovf_udf,
    input  logic             upd_ev,
    input  logic             trig,
    output logic [WR_W-1:0]  cfg_rdata,
    output logic             oref
);
    cfg_t             cfg;
    logic [CNT_W-1:0] cmp_act;

    pwmc_cfg_reg #(.WR_W(WR_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_cfg(wr_en && !wr_sel),
        .wdata (wr_data),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    pwmc_cmp_shadow #(.CNT_W(CNT_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_cmp(wr_en && wr_sel),
        .wdata (wr_data[CNT_W-1:0]),
        .pre   (cfg.pre),
        .upd   (upd_ev),
        .act   (cmp_act)
    );

    pwmc_out_gen #(.CNT_W(CNT_W)) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt),
        .cmp  (cmp_act),
        .mode (cfg.mode),
        .imae (cfg.imae),
        .trig (trig),
        .ovf  (ovf_udf),
        .oref (oref)
    );

    // R1: output low in the first cycle after reset
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> !oref);
endmodule

// File: tb/sim_pwm_compare_channel.sv
module sim_pwm_compare_channel;
    localparam int CW = 8;
    localparam int WW = 9;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_en = 0, wr_sel = 0;
    logic [WW-1:0] wr_data = '0;
    logic [CW-1:0] cnt = '0;
    logic          ovf_udf = 0, upd_ev = 0, trig = 0;
    logic [WW-1:0] cfg_rdata;
    logic          oref;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    pwm_compare_channel #(.CNT_W(CW)) u0 (.*);

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int val, input logic u);
        wr_en = 1; wr_sel = sel; wr_data = WW'(val); upd_ev = u;
        @(posedge clk); @(negedge clk);
        wr_en = 0; upd_ev = 0;
    endtask

    task automatic set_cfg(input int mode, input logic pre, input logic im);
        wr(1'b0, ((mode >> 3) << 8) | (mode & 7) | (int'(pre) << 4) | (int'(im) << 5), 1'b0);
    endtask

    task automatic step(input int c, input logic t, input logic o, input logic u);
        cnt = CW'(c); trig = t; ovf_udf = o; upd_ev = u;
        @(posedge clk); @(negedge clk);
        trig = 0; ovf_udf = 0; upd_ev = 0;
    endtask

    function automatic int pwm_exp(input bit hi, input int c, input int cm);
        return (c < cm) ? int'(!hi) : int'(hi);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cmps[6] = '{0, 1, 2, 100, 254, 255};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(int'(cfg_rdata), 0, "R1 cfg");
        chk(int'(oref), 0, "R1 oref");
        // R2 layout
        wr(1'b0, 'h1FF, 1'b0);
        chk(int'(cfg_rdata), 'h137, "R2 all ones");
        wr(1'b0, 'h0C8, 1'b0);
        chk(int'(cfg_rdata), 0, "R2 reserved only");
        // R3/R4 duty sweeps, direct loads (R6)
        for (int m = 0; m < 2; m++) begin
            set_cfg(6 + m, 1'b0, 1'b0);
            foreach (cmps[k]) begin
                wr(1'b1, cmps[k], 1'b0);
                for (int c = 0; c < 256; c++) begin
                    step(c, 0, 0, 0);
                    chk(int'(oref), pwm_exp(m[0], c, cmps[k]), m ? "R4 duty" : "R3 duty");
                end
            end
        end
        // R6 direct write takes effect next cycle
        set_cfg(6, 1'b0, 1'b0);
        wr(1'b1, 50, 1'b0);
        step(100, 0, 0, 0);
        chk(int'(oref), 0, "R6 before");
        wr(1'b1, 200, 1'b0);
        step(100, 0, 0, 0);
        chk(int'(oref), 1, "R6 after");
        // R5 other modes, including mode bit 3
        for (int md = 0; md < 16; md++) begin
            if (md == 6 || md == 7) continue;
            set_cfg(md, 1'b0, 1'b0);
            step(10, 0, 0, 0);
            chk(int'(oref), 0, "R5 mode");
            step(250, 0, 0, 0);
            chk(int'(oref), 0, "R5 mode hi");
        end
        // R7 preload
        set_cfg(6, 1'b0, 1'b0);
        wr(1'b1, 50, 1'b0);
        set_cfg(6, 1'b1, 1'b0);
        wr(1'b1, 200, 1'b0);
        step(100, 0, 0, 0);
        chk(int'(oref), 0, "R7 held");
        step(100, 0, 0, 0);
        chk(int'(oref), 0, "R7 still held");
        step(100, 0, 0, 1);
        step(100, 0, 0, 0);
        chk(int'(oref), 1, "R7 after update");
        wr(1'b1, 20, 1'b1);
        step(100, 0, 0, 0);
        chk(int'(oref), 0, "R7 same-edge write+update");
        // R8/R9 forced period, first pulse mode
        set_cfg(6, 1'b0, 1'b1);
        wr(1'b1, 200, 1'b0);
        step(10, 0, 0, 0);
        chk(int'(oref), 1, "R8 pre-trigger");
        step(10, 1, 0, 0);
        chk(int'(oref), 0, "R8 forced lvl pwm1");
        step(20, 0, 0, 0);
        chk(int'(oref), 0, "R9 forced holds");
        step(30, 1, 0, 0);
        chk(int'(oref), 0, "R9 retrigger ignored");
        step(40, 0, 1, 0);
        chk(int'(oref), 1, "R9 ends at ovf");
        step(40, 1, 1, 0);
        chk(int'(oref), 1, "R9 trig+ovf");
        step(40, 0, 0, 0);
        chk(int'(oref), 1, "R9 trig+ovf no force");
        // R8 second pulse mode
        set_cfg(7, 1'b0, 1'b1);
        step(250, 0, 0, 0);
        chk(int'(oref), 1, "R4 pre-trigger");
        step(5, 1, 0, 0);
        chk(int'(oref), 1, "R8 forced lvl pwm2");
        step(6, 0, 0, 0);
        chk(int'(oref), 1, "R8 hold pwm2");
        step(7, 0, 1, 0);
        chk(int'(oref), 0, "R9 end pwm2");
        // R10 imae off
        set_cfg(6, 1'b0, 1'b0);
        step(10, 1, 0, 0);
        chk(int'(oref), 1, "R10 imae off");
        // R10 non-pulse mode trigger, then switch to pulse mode
        set_cfg(2, 1'b0, 1'b1);
        step(10, 1, 0, 0);
        chk(int'(oref), 0, "R10 non-pwm out");
        set_cfg(6, 1'b0, 1'b1);
        step(10, 0, 0, 0);
        chk(int'(oref), 1, "R10 no latent force");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule